// File: doc/BRIEF.md
# 1-Wire ROM Command Layer

This block is the addressing stage of a 1-Wire slave. It runs after every reset/presence cycle. It takes one 8-bit command from the bus master, least significant bit first, and acts on a 64-bit device identifier. The identifier holds an 8-bit family code in bits 7:0, a 48-bit serial number in bits 55:8 and an 8-bit CRC in bits 63:56. Depending on the command, the block sends the identifier, compares it against one sent by the master, takes part in a search, or simply selects the device. When selection succeeds, it grants the device function layer access to the bus.

A separate bit engine handles the slot timing. It passes each sampled time slot to this block as a one-cycle strobe carrying the sampled bus level. It also signals each bus reset as a strobe, with a flag that marks a reset long enough to end overdrive. The block answers with a pull-low request, which the bit engine applies in the next slot. The wired-AND bus means that a slave sending a 1 simply does not pull low. The block also keeps a resume flag and drives the speed level that the bit engine uses.

Top module: `owrom_layer`

## Requirements
- R1: Before the first bus reset, and after any bus reset, `func_en_o` and `drv_low_o` are 0. A bus reset aborts any command in progress, and the next 8 slots are taken as a new command code, least significant bit first.
- R2: Code 33h (read) makes the next 64 slots send identifier bits 0 to 63 in order. `drv_low_o` is 1 exactly when the current bit is 0. Access is granted after the 64th slot.
- R3: Code 55h (match) compares 64 received bits, bit 0 first, against the identifier. A full match grants access. On any mismatch the block neither pulls low nor grants access until the next bus reset.
- R4: Code F0h (search) handles each identifier bit, bit 0 first, as three slots. The block sends the true bit, then its complement, then reads the master's choice. If the choice differs from its own bit, the block stops driving until the next reset. After all 64 bits agree, access is granted.
- R5: Code CCh (skip) grants access right after the command byte, and access stays granted until the next bus reset.
- R6: Codes 33h, 55h, F0h, CCh, 3Ch and 69h clear the resume flag when they are decoded. A completed match, search or overdrive-match sets it. Code A5h grants access only if the flag is set; otherwise the block goes silent until the next reset. The flag is 0 after `rst_n`.
- R7: Code 3Ch (overdrive-skip) sets `od_o` to 1 and grants access right after the command byte.
- R8: Code 69h (overdrive-match) sets `od_o` to 1 right after the command byte, then runs the 64-bit compare. A full match grants access. A mismatch clears `od_o` and silences the block until the next reset.
- R9: A bus reset with `rst_long_i` high clears `od_o`. A bus reset with `rst_long_i` low leaves `od_o` unchanged.
- R10: Any other command code silences the block (no pull-low, no access) until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_id_i | input | 64 | Device identifier: family code [7:0], serial number [55:8], CRC [63:56] |
| rst_stb_i | input | 1 | One-cycle strobe: bus reset detected |
| rst_long_i | input | 1 | Qualifies `rst_stb_i`: reset long enough to leave overdrive |
| slot_stb_i | input | 1 | One-cycle strobe: a time slot was sampled |
| slot_rx_i | input | 1 | Bus level sampled in that slot |
| drv_low_o | output | 1 | Request to pull the bus low in the next slot |
| func_en_o | output | 1 | Access granted to the function layer |
| od_o | output | 1 | Overdrive speed selected |

## Verification
The checks take for granted that a bus reset strobe and a slot strobe never arrive in the same cycle, that each strobe lasts exactly one cycle, and that the identifier does not change while the block runs. The bench issues every reset and every slot from a task that raises one strobe for one cycle at the falling clock edge, with idle cycles in between. It draws identifiers once per scenario and holds them stable. The bus level it returns is the wired-AND of the master's bit and the block's pull-low request, which models a single slave on the bus.

// File: rtl/owrom_layer.sv
module owrom_layer #(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] rom_id_i,
  input  logic            rst_stb_i,
  input  logic            rst_long_i,
  input  logic            slot_stb_i,
  input  logic            slot_rx_i,
  output logic            drv_low_o,
  output logic            func_en_o,
  output logic            od_o
);
  localparam int IW = $clog2(ID_W);
  localparam int CW = 8;

  typedef enum logic [2:0] {S_CMD, S_READ, S_MATCH, S_SRCH, S_FUNC, S_IDLE} st_t;

  st_t           st;
  logic [IW-1:0] idx;
  logic [1:0]    ph;
  logic [CW-1:0] sh;
  logic          rc, odm;

  wire          id_bit = rom_id_i[idx];
  wire          last   = (idx == IW'(ID_W - 1));
  wire [CW-1:0] code   = {slot_rx_i, sh[CW-1:1]};

  assign drv_low_o = ((st == S_READ) && !id_bit) ||
                     ((st == S_SRCH) && (ph == 2'd0) && !id_bit) ||
                     ((st == S_SRCH) && (ph == 2'd1) && id_bit);
  assign func_en_o = (st == S_FUNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
      ph  <= '0;
      sh  <= '0;
      rc  <= 1'b0;
      odm <= 1'b0;
      od_o <= 1'b0;
    end else if (rst_stb_i) begin
      st  <= S_CMD;
      idx <= '0;
      ph  <= '0;
      if (rst_long_i) od_o <= 1'b0;
    end else if (slot_stb_i) begin
      case (st)
        S_CMD: begin
          sh  <= code;
          idx <= idx + 1'b1;
          if (idx == IW'(CW - 1)) begin
            idx <= '0;
            ph  <= '0;
            odm <= 1'b0;
            case (code)
              8'h33: begin st <= S_READ;  rc <= 1'b0; end
              8'h55: begin st <= S_MATCH; rc <= 1'b0; end
              8'hF0: begin st <= S_SRCH;  rc <= 1'b0; end
              8'hCC: begin st <= S_FUNC;  rc <= 1'b0; end
              8'hA5: st <= rc ? S_FUNC : S_IDLE;
              8'h3C: begin st <= S_FUNC;  rc <= 1'b0; od_o <= 1'b1; end
              8'h69: begin st <= S_MATCH; rc <= 1'b0; od_o <= 1'b1; odm <= 1'b1; end
              default: st <= S_IDLE;
            endcase
          end
        end
        S_READ: begin
          idx <= idx + 1'b1;
          if (last) st <= S_FUNC;
        end
        S_MATCH: begin
          idx <= idx + 1'b1;
          if (slot_rx_i != id_bit) begin
            st <= S_IDLE;
            if (odm) od_o <= 1'b0;
          end else if (last) begin
            st <= S_FUNC;
            rc <= 1'b1;
          end
        end
        S_SRCH: begin
          if (ph != 2'd2) ph <= ph + 1'b1;
          else begin
            ph  <= '0;
            idx <= idx + 1'b1;
            if (slot_rx_i != id_bit) st <= S_IDLE;
            else if (last) begin
              st <= S_FUNC;
              rc <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/owrom_layer_chk.sv
module owrom_layer_chk #(
  parameter int ID_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ID_W-1:0] rom_id_i,
  input logic            rst_stb_i,
  input logic            rst_long_i,
  input logic            slot_stb_i,
  input logic            slot_rx_i,
  input logic            drv_low_o,
  input logic            func_en_o,
  input logic            od_o
);
  p_strobes_apart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_stb_i && slot_stb_i));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_stb_i |=> (!func_en_o && !drv_low_o));

  p_grant_on_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(func_en_o) |-> $past(slot_stb_i));

  p_grant_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en_o && !rst_stb_i) |=> func_en_o);

  p_od_on_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(od_o) |-> $past(slot_stb_i));

  p_long_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_stb_i && rst_long_i) |=> !od_o);

  p_short_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_stb_i && !rst_long_i) |=> $stable(od_o));

  p_granted_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    func_en_o |-> !drv_low_o);
endmodule

bind owrom_layer owrom_layer_chk #(.ID_W(ID_W)) u_chk (.*);

// File: tb/sim_owrom_layer.sv
`timescale 1ns/1ps
module sim_owrom_layer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] rom_id = '0;
  logic        rst_stb = 1'b0, rst_long = 1'b0, slot_stb = 1'b0, slot_rx = 1'b0;
  logic        drv_low, func_en, od;
  int          nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  owrom_layer u0 (
    .clk(clk), .rst_n(rst_n), .rom_id_i(rom_id),
    .rst_stb_i(rst_stb), .rst_long_i(rst_long),
    .slot_stb_i(slot_stb), .slot_rx_i(slot_rx),
    .drv_low_o(drv_low), .func_en_o(func_en), .od_o(od)
  );

  function automatic bit known(input logic [7:0] c);
    return c inside {8'h33, 8'h55, 8'hF0, 8'hCC, 8'hA5, 8'h3C, 8'h69};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_reset(input logic lng);
    @(negedge clk); rst_stb = 1'b1; rst_long = lng;
    @(negedge clk); rst_stb = 1'b0; rst_long = 1'b0;
    @(negedge clk);
  endtask

  task automatic slot(input logic mval, output logic got);
    @(negedge clk);
    got = mval & ~drv_low;
    slot_stb = 1'b1; slot_rx = got;
    @(negedge clk); slot_stb = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic g;
    for (int i = 0; i < 8; i++) slot(b[i], g);
  endtask

  task automatic read_bits(input int n, output logic [63:0] v);
    logic g;
    v = '1;
    for (int i = 0; i < n; i++) begin slot(1'b1, g); v[i] = g; end
  endtask

  task automatic send_id(input logic [63:0] v);
    logic g;
    for (int i = 0; i < 64; i++) slot(v[i], g);
  endtask

  task automatic run_search(input logic [63:0] id, input int dev, output logic [63:0] t, output logic [63:0] c);
    logic g;
    t = '1; c = '1;
    for (int i = 0; i < 64; i++) begin
      slot(1'b1, g); t[i] = g;
      slot(1'b1, g); c[i] = g;
      slot((i == dev) ? ~id[i] : id[i], g);
    end
  endtask

  task automatic resume_expect(input logic exp, input string req);
    logic [63:0] v;
    bus_reset(1'b0);
    send_byte(8'hA5);
    check(req, func_en, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [63:0] v, t, c, bad;
    logic [7:0]  code;
    int          k;
    void'($urandom(32'd2024));
    rom_id = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset func", func_en, 0);
    check("R1 reset od", od, 0);
    check("R1 reset drive", drv_low, 0);

    // R2 read
    bus_reset(1'b0);
    check("R1 after bus reset", func_en, 0);
    send_byte(8'h33);
    read_bits(64, v);
    check("R2 read id", v, rom_id);
    check("R2 grant", func_en, 1);
    bus_reset(1'b0);
    check("R1 reset drops grant", func_en, 0);
    send_byte(8'hA5);
    check("R6 resume after read", func_en, 0);
    read_bits(8, v);
    check("R6 silent after refused resume", v[7:0], 8'hFF);

    // R3 match good, then resume
    bus_reset(1'b0);
    send_byte(8'h55);
    send_id(rom_id);
    check("R3 match grant", func_en, 1);
    resume_expect(1'b1, "R6 resume after match");
    resume_expect(1'b1, "R6 repeated resume");

    // R1 abort mid command
    bus_reset(1'b0);
    send_byte(8'h55);
    for (int i = 0; i < 10; i++) slot(rom_id[i], v[0]);
    bus_reset(1'b0);
    send_byte(8'hCC);
    check("R1 abort then skip", func_en, 1);

    // R3 mismatch
    k = $urandom_range(63);
    bad = rom_id; bad[k] = ~bad[k];
    bus_reset(1'b0);
    send_byte(8'h55);
    send_id(bad);
    check("R3 mismatch no grant", func_en, 0);
    read_bits(8, v);
    check("R3 silent after mismatch", v[7:0], 8'hFF);
    resume_expect(1'b0, "R6 match cleared flag");

    // R4 search complete
    bus_reset(1'b0);
    send_byte(8'hF0);
    run_search(rom_id, -1, t, c);
    check("R4 search true bits", t, rom_id);
    check("R4 search complement bits", c, ~rom_id);
    check("R4 search grant", func_en, 1);
    resume_expect(1'b1, "R6 resume after search");

    // R4 search drop out
    k = $urandom_range(1, 62);
    bus_reset(1'b0);
    send_byte(8'hF0);
    run_search(rom_id, k, t, c);
    check("R4 dropout true", t, rom_id | ~((64'd2 << k) - 64'd1));
    check("R4 dropout comp", c, ~rom_id | ~((64'd2 << k) - 64'd1));
    check("R4 dropout no grant", func_en, 0);

    // R5 skip
    bus_reset(1'b0);
    send_byte(8'hCC);
    check("R5 skip grant", func_en, 1);
    repeat (5) slot(1'b1, v[0]);
    check("R5 grant held", func_en, 1);
    resume_expect(1'b0, "R6 skip cleared flag");

    // R7 / R9 overdrive skip
    bus_reset(1'b0);
    send_byte(8'h3C);
    check("R7 od skip od", od, 1);
    check("R7 od skip grant", func_en, 1);
    bus_reset(1'b0);
    check("R9 short reset keeps od", od, 1);
    resume_expect(1'b0, "R7 od skip cleared flag");
    bus_reset(1'b1);
    check("R9 long reset clears od", od, 0);

    // R8 overdrive match
    bus_reset(1'b0);
    send_byte(8'h69);
    check("R8 od after code", od, 1);
    send_id(rom_id);
    check("R8 od match grant", func_en, 1);
    check("R8 od kept", od, 1);
    resume_expect(1'b1, "R6 resume after od match");
    bus_reset(1'b1);
    k = $urandom_range(63);
    bad = rom_id; bad[k] = ~bad[k];
    send_byte(8'h69);
    send_id(bad);
    check("R8 mismatch od", od, 0);
    check("R8 mismatch grant", func_en, 0);

    // R10 unknown codes
    for (int n = 0; n < 4; n++) begin
      do code = 8'($urandom); while (known(code));
      bus_reset(1'b0);
      send_byte(code);
      check("R10 unknown no grant", func_en, 0);
      read_bits(16, v);
      check("R10 unknown silent", v[15:0], 16'hFFFF);
    end

    // random mix
    for (int n = 0; n < 20; n++) begin
      rom_id = {$urandom, $urandom};
      bus_reset(1'b1);
      case ($urandom_range(2))
        0: begin
          send_byte(8'h33); read_bits(64, v);
          check("R2 random read", v, rom_id);
        end
        1: begin
          k = $urandom_range(64);
          bad = rom_id; if (k < 64) bad[k] = ~bad[k];
          send_byte(8'h55); send_id(bad);
          check("R3 random match", func_en, (k == 64));
        end
        default: begin
          k = $urandom_range(64);
          bad = rom_id; if (k < 64) bad[k] = ~bad[k];
          send_byte(8'h69); send_id(bad);
          check("R8 random od match", {func_en, od}, (k == 64) ? 2'b11 : 2'b00);
        end
      endcase
    end

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule